// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Unit

This block keeps the cause, status and sequence-step registers of a bus controller's host interface. It drives one level-sensitive interrupt line toward the processor. Protocol logic elsewhere in the controller reports events to it on a one-cycle event strobe. Each event carries a cause byte, a transfer-count flag, a phase code and a sequence step. The event loads all of these into the registers and raises the interrupt.

Software uses a byte-wide register port. Reading the cause register returns its current value and also acknowledges the interrupt, so the read has side effects. Three commands written to the command register act on the interrupt logic directly: bus reset, selection enable and selection disable. A configuration bit can keep a bus reset from being reported. A soft-reset command returns every register to its reset value.

Register map, by address: 0 is status (read only), 1 is cause (read only, cleared by a read), 2 is step (read only), 3 is configuration (read/write) and 4 is command (write only). Addresses 4 to 7 read as zero.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status, cause and step read 0, configuration reads 0x07 and `irq_o` is low.
- R2: An event strobe loads cause with `evt_cause` and step with `evt_step`. It loads status with bit 7 (INT) = 1, bit 4 (TC) = `evt_tc`, bits 2:0 = `evt_phase` and every other bit 0. It sets `irq_o` at the next clock edge.
- R3: During a read strobe at address 1, `reg_rdata` shows the cause value held before that read.
- R4: At the edge of a read at address 1, cause goes to 0 and status bits 7 and 4 are cleared while its other bits are kept. Step becomes 4 and `irq_o` falls.
- R5: When an event and a read at address 1 fall in the same cycle, the event's cause, status and step are kept and `irq_o` stays high.
- R6: Writing command 0x03 (bus reset) loads cause with 0x80. When configuration bit 6 is 0, it also sets status bit 7 and raises `irq_o`.
- R7: When configuration bit 6 is 1, command 0x03 still loads cause with 0x80 but leaves `irq_o` and status bit 7 unchanged.
- R8: Command 0x45 (selection disable) zeroes cause, then sets status bit 7 and raises `irq_o`.
- R9: Command 0x44 (selection enable) zeroes cause and leaves `irq_o` and status unchanged.
- R10: Command 0x02 (soft reset) returns all registers to their R1 values at the next edge, including configuration, and drives `irq_o` low. Command bit 7 is ignored in decoding.
- R11: The following have no effect on any register or on `irq_o`: writes to addresses 0, 1, 2, 5, 6 and 7, and unknown command codes such as 0x7F.
- R12: An event arriving while `irq_o` is already high keeps `irq_o` high and loads the new cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| evt_valid | input | 1 | Event strobe from the controller |
| evt_cause | input | 8 | Event cause byte |
| evt_tc | input | 1 | Event transfer-count flag |
| evt_phase | input | PHASE_W | Event phase code |
| evt_step | input | STEP_W | Event sequence step |
| irq_o | output | 1 | Registered level interrupt |

## Verification
`reg_rdata` is combinational from the address. The pre-read cause value is therefore due in the same cycle as the read strobe, and the bench samples it 1 ns after driving the strobe on the falling edge. Every register effect and every change of `irq_o` is due one edge later. After each rising edge the bench releases the strobes, then sweeps all eight addresses and compares them with a model it updates at that same edge. This way no check ever looks at a value before the edge that produces it.

// File: rtl/isu_pkg.sv
`timescale 1ns/1ps
package isu_pkg;
  localparam int BYTE_W   = 8;
  localparam int INT_POS  = 7;
  localparam int TC_POS   = 4;
  localparam int PH_FLD_W = 4;

  localparam int A_STAT  = 0;
  localparam int A_CAUSE = 1;
  localparam int A_STEP  = 2;
  localparam int A_CFG   = 3;
  localparam int A_CMD   = 4;

  typedef enum logic [6:0] {
    OP_NOP      = 7'h00,
    OP_SOFT_RST = 7'h02,
    OP_BUS_RST  = 7'h03,
    OP_SEL_ON   = 7'h44,
    OP_SEL_OFF  = 7'h45
  } isu_op_e;

  // status word built by an event
  function automatic logic [BYTE_W-1:0] stat_load(input logic tc, input logic [PH_FLD_W-1:0] ph);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[INT_POS] = 1'b1;
    s[TC_POS]  = tc;
    s[PH_FLD_W-1:0] = ph;
    return s;
  endfunction

  // status word after a destructive cause read
  function automatic logic [BYTE_W-1:0] stat_ack(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] r;
    r = s;
    r[INT_POS] = 1'b0;
    r[TC_POS]  = 1'b0;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] stat_raise(input logic [BYTE_W-1:0] s);
    logic [BYTE_W-1:0] r;
    r = s;
    r[INT_POS] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/isu_decode.sv
`timescale 1ns/1ps
module isu_decode
  import isu_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic              rd_cause,
  output logic              wr_cfg,
  output logic              op_soft,
  output logic              op_bus,
  output logic              op_sel_on,
  output logic              op_sel_off
);
  logic              wr_cmd;
  logic [BYTE_W-1:0] code;

  assign rd_cause = reg_rd && (reg_addr == ADDR_W'(A_CAUSE));
  assign wr_cfg   = reg_wr && (reg_addr == ADDR_W'(A_CFG));
  assign wr_cmd   = reg_wr && (reg_addr == ADDR_W'(A_CMD));
  // command bit 7 carries no meaning here
  assign code     = reg_wdata & 8'h7F;

  assign op_soft    = wr_cmd && (code == {1'b0, OP_SOFT_RST});
  assign op_bus     = wr_cmd && (code == {1'b0, OP_BUS_RST});
  assign op_sel_on  = wr_cmd && (code == {1'b0, OP_SEL_ON});
  assign op_sel_off = wr_cmd && (code == {1'b0, OP_SEL_OFF});
endmodule

// File: rtl/isu_regs.sv
`timescale 1ns/1ps
module isu_regs
  import isu_pkg::*;
#(
  parameter int                PHASE_W   = 3,
  parameter int                STEP_W    = 3,
  parameter logic [BYTE_W-1:0] CFG_RESET = 8'h07,
  parameter int                MUTE_BIT  = 6,
  parameter int                STEP_DONE = 4,
  parameter logic [BYTE_W-1:0] CAUSE_BUS = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_cause,
  input  logic               wr_cfg,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               op_soft,
  input  logic               op_bus,
  input  logic               op_sel_on,
  input  logic               op_sel_off,
  input  logic               evt_valid,
  input  logic [BYTE_W-1:0]  evt_cause,
  input  logic               evt_tc,
  input  logic [PHASE_W-1:0] evt_phase,
  input  logic [STEP_W-1:0]  evt_step,
  output logic [BYTE_W-1:0]  status_q,
  output logic [BYTE_W-1:0]  cause_q,
  output logic [STEP_W-1:0]  step_q,
  output logic [BYTE_W-1:0]  cfg_q,
  output logic               irq_q
);
  localparam logic [STEP_W-1:0] STEP_ACK = STEP_W'(STEP_DONE);

  logic [BYTE_W-1:0]   status_n, cause_n, cfg_n;
  logic [STEP_W-1:0]   step_n;
  logic                irq_n;
  logic                bus_report;
  logic                raise_cmd;
  logic [PH_FLD_W-1:0] ph_ext;

  assign bus_report = op_bus && !cfg_q[MUTE_BIT];
  assign raise_cmd  = bus_report || op_sel_off;
  assign ph_ext     = PH_FLD_W'(evt_phase);

  // priority, lowest first: cfg write, read ack, commands, event
  always_comb begin
    status_n = status_q;
    cause_n  = cause_q;
    step_n   = step_q;
    cfg_n    = cfg_q;
    irq_n    = irq_q;
    if (wr_cfg) cfg_n = wdata;
    if (rd_cause) begin
      cause_n  = '0;
      status_n = stat_ack(status_q);
      step_n   = STEP_ACK;
      irq_n    = 1'b0;
    end
    if (op_bus)     cause_n = CAUSE_BUS;
    if (op_sel_on)  cause_n = '0;
    if (op_sel_off) cause_n = '0;
    if (raise_cmd) begin
      status_n = stat_raise(status_n);
      irq_n    = 1'b1;
    end
    if (evt_valid) begin
      cause_n  = evt_cause;
      status_n = stat_load(evt_tc, ph_ext);
      step_n   = evt_step;
      irq_n    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      cause_q  <= '0;
      step_q   <= '0;
      cfg_q    <= CFG_RESET;
      irq_q    <= 1'b0;
    end else if (op_soft) begin
      status_q <= '0;
      cause_q  <= '0;
      step_q   <= '0;
      cfg_q    <= CFG_RESET;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      cause_q  <= cause_n;
      step_q   <= step_n;
      cfg_q    <= cfg_n;
      irq_q    <= irq_n;
    end
  end

  // R2
  evt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !op_soft) |=> (irq_q && status_q[INT_POS] && cause_q == $past(evt_cause)));

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && !evt_valid && !op_soft && !op_bus && !op_sel_off)
      |=> (!irq_q && cause_q == '0 && !status_q[TC_POS] && step_q == STEP_ACK));

  // R7
  bus_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_bus && cfg_q[MUTE_BIT] && !evt_valid && !op_sel_off && !irq_q && !op_soft) |=> !irq_q);

  // R10
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_soft |=> (cfg_q == CFG_RESET && !irq_q && cause_q == '0 && status_q == '0));

  // R12
  line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == status_q[INT_POS]);
endmodule

// File: rtl/isu_rdmux.sv
`timescale 1ns/1ps
module isu_rdmux
  import isu_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int STEP_W = 3
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] status_q,
  input  logic [BYTE_W-1:0] cause_q,
  input  logic [STEP_W-1:0] step_q,
  input  logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if      (reg_addr == ADDR_W'(A_STAT))  rdata = status_q;
    else if (reg_addr == ADDR_W'(A_CAUSE)) rdata = cause_q;
    else if (reg_addr == ADDR_W'(A_STEP))  rdata = BYTE_W'(step_q);
    else if (reg_addr == ADDR_W'(A_CFG))   rdata = cfg_q;
  end
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int                ADDR_W    = 3,
  parameter int                PHASE_W   = 3,
  parameter int                STEP_W    = 3,
  parameter logic [BYTE_W-1:0] CFG_RESET = 8'h07,
  parameter int                MUTE_BIT  = 6,
  parameter int                STEP_DONE = 4,
  parameter logic [BYTE_W-1:0] CAUSE_BUS = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  input  logic               evt_valid,
  input  logic [BYTE_W-1:0]  evt_cause,
  input  logic               evt_tc,
  input  logic [PHASE_W-1:0] evt_phase,
  input  logic [STEP_W-1:0]  evt_step,
  output logic               irq_o
);
  logic              rd_cause, wr_cfg, op_soft, op_bus, op_sel_on, op_sel_off;
  logic [BYTE_W-1:0] status_q, cause_q, cfg_q;
  logic [STEP_W-1:0] step_q;

  isu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .rd_cause(rd_cause), .wr_cfg(wr_cfg), .op_soft(op_soft), .op_bus(op_bus),
    .op_sel_on(op_sel_on), .op_sel_off(op_sel_off)
  );

  isu_regs #(
    .PHASE_W(PHASE_W), .STEP_W(STEP_W), .CFG_RESET(CFG_RESET),
    .MUTE_BIT(MUTE_BIT), .STEP_DONE(STEP_DONE), .CAUSE_BUS(CAUSE_BUS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_cause(rd_cause), .wr_cfg(wr_cfg), .wdata(reg_wdata),
    .op_soft(op_soft), .op_bus(op_bus), .op_sel_on(op_sel_on), .op_sel_off(op_sel_off),
    .evt_valid(evt_valid), .evt_cause(evt_cause), .evt_tc(evt_tc),
    .evt_phase(evt_phase), .evt_step(evt_step),
    .status_q(status_q), .cause_q(cause_q), .step_q(step_q), .cfg_q(cfg_q), .irq_q(irq_o)
  );

  isu_rdmux #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_mux (
    .reg_addr(reg_addr), .status_q(status_q), .cause_q(cause_q),
    .step_q(step_q), .cfg_q(cfg_q), .rdata(reg_rdata)
  );
endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_valid = 1'b0;
  logic [7:0] evt_cause = '0;
  logic       evt_tc = 1'b0;
  logic [2:0] evt_phase = '0;
  logic [2:0] evt_step = '0;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_stat, m_cause, m_cfg;
  logic [2:0] m_step;
  logic       m_irq;

  always #10 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_cause(evt_cause), .evt_tc(evt_tc), .evt_phase(evt_phase),
    .evt_step(evt_step), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int a);
    case (a)
      0: return m_stat;
      1: return m_cause;
      2: return {5'b0, m_step};
      3: return m_cfg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic sweep(input string tag);
    chk({tag, " irq"}, {7'b0, irq_o}, {7'b0, m_irq});
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #1;
      chk($sformatf("%s reg%0d", tag, a), reg_rdata, exp_reg(a));
    end
  endtask

  task automatic model_reset();
    m_stat = 0; m_cause = 0; m_step = 0; m_cfg = 8'h07; m_irq = 0;
  endtask

  task automatic apply(input bit ev, input logic [7:0] ec, input bit tc,
                       input logic [2:0] ph, input logic [2:0] st,
                       input bit rd, input bit wr, input logic [2:0] a,
                       input logic [7:0] wd, input string tag);
    logic [7:0] old_cfg, op;
    @(negedge clk);
    evt_valid = ev; evt_cause = ec; evt_tc = tc; evt_phase = ph; evt_step = st;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    if (rd && a == 3'd1) chk("R3 pre-read cause", reg_rdata, m_cause);
    @(posedge clk);
    old_cfg = m_cfg;
    op = wd & 8'h7F;
    if (wr && a == 3'd4 && op == 8'h02) model_reset();
    else begin
      if (wr && a == 3'd3) m_cfg = wd;
      if (rd && a == 3'd1) begin
        m_cause = 0; m_stat = m_stat & 8'h6F; m_step = 3'd4; m_irq = 0;
      end
      if (wr && a == 3'd4) begin
        if (op == 8'h03) begin
          m_cause = 8'h80;
          if (!old_cfg[6]) begin m_stat[7] = 1; m_irq = 1; end
        end
        if (op == 8'h44) m_cause = 0;
        if (op == 8'h45) begin m_cause = 0; m_stat[7] = 1; m_irq = 1; end
      end
      if (ev) begin
        m_cause = ec; m_step = st; m_irq = 1;
        m_stat = {1'b1, 2'b00, tc, 1'b0, ph};
      end
    end
    #1;
    evt_valid = 0; reg_rd = 0; reg_wr = 0;
    sweep(tag);
  endtask

  task automatic rdc(input string tag);
    apply(0, 0, 0, 0, 0, 1, 0, 3'd1, 0, tag);
  endtask

  task automatic cmd(input logic [7:0] c, input string tag);
    apply(0, 0, 0, 0, 0, 0, 1, 3'd4, c, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; sweep("R1 reset");

    apply(1, 8'h18, 1, 3'd5, 3'd3, 0, 0, 0, 0, "R2 event");
    rdc("R4 ack");
    apply(1, 8'h21, 0, 3'd2, 3'd1, 0, 0, 0, 0, "R2 event2");
    apply(1, 8'h33, 1, 3'd7, 3'd6, 0, 0, 0, 0, "R12 event while pending");
    apply(1, 8'h44, 1, 3'd1, 3'd2, 1, 0, 3'd1, 0, "R5 event with read");
    rdc("R4 ack2");
    cmd(8'h03, "R6 bus reset reported");
    rdc("R4 ack3");
    apply(0, 0, 0, 0, 0, 0, 1, 3'd3, 8'h47, "R7 cfg write");
    cmd(8'h03, "R7 bus reset muted");
    cmd(8'h45, "R8 sel off");
    apply(1, 8'h5A, 0, 3'd3, 3'd5, 0, 0, 0, 0, "R9 event");
    cmd(8'h44, "R9 sel on while pending");
    rdc("R4 ack4");
    cmd(8'h44, "R9 sel on idle");
    apply(1, 8'h66, 1, 3'd4, 3'd2, 0, 0, 0, 0, "R11 setup");
    apply(0, 0, 0, 0, 0, 0, 1, 3'd0, 8'hFF, "R11 write stat");
    apply(0, 0, 0, 0, 0, 0, 1, 3'd1, 8'hFF, "R11 write cause");
    apply(0, 0, 0, 0, 0, 0, 1, 3'd2, 8'hFF, "R11 write step");
    apply(0, 0, 0, 0, 0, 0, 1, 3'd5, 8'hFF, "R11 write addr5");
    cmd(8'h7F, "R11 unknown cmd");
    cmd(8'h82, "R10 soft reset");

    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      k = $urandom % 10;
      if (k < 4)
        apply(1, 8'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
              1'($urandom % 4 == 0), 0, 3'd1, 0, "R2 random event");
      else if (k < 7) rdc("R4 random read");
      else if (k == 7)
        apply(0, 0, 0, 0, 0, 0, 1, 3'd3, {1'b0, 1'($urandom), 6'h07}, "R7 random cfg");
      else begin
        int unsigned c;
        c = $urandom % 5;
        case (c)
          0: cmd(8'h03, "R6 random bus reset");
          1: cmd(8'h44, "R9 random sel on");
          2: cmd(8'h45, "R8 random sel off");
          3: cmd(8'h7F, "R11 random bad cmd");
          default: cmd(8'h00, "R11 random nop");
        endcase
      end
    end
    cmd(8'h02, "R10 final soft reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule